// File: doc/BRIEF.md
# Black-Level Measurement Window Timer

This block times the short interval in which a black-level offset measurement is taken on a video input. It watches a clamp pulse that is synchronous to the pixel clock and raises a measurement-active strobe for a fixed number of pixel clocks. A one-cycle completion pulse follows the strobe. The logic that computes the offset and the analog clamp are outside the block.

There are two placements for the window. In the in-clamp placement the strobe starts as soon as the clamp pulse is seen to begin. In the post-clamp placement the block waits for the clamp pulse to end and then counts a selectable delay of 10 or 16 pixel clocks before it opens the strobe. Two configuration bits choose the placement and the delay. Both bits are held in registers that load on a write strobe, and each sequence captures the settings in force when its clamp pulse begins.

The controller is a five-state machine with these states:
- `ST_IDLE` is the rest state.
- `ST_ARMED` waits for the clamp to end in post-clamp placement.
- `ST_DELAY` counts the post-clamp delay.
- `ST_WINDOW` drives the strobe.
- `ST_DONE` drives the completion pulse.

It has these transitions:
- A clamp rise moves any state to `ST_WINDOW` in in-clamp placement, or to `ST_ARMED` in post-clamp placement.
- `ST_ARMED` goes to `ST_DELAY` on a clamp fall.
- `ST_DELAY` goes to `ST_WINDOW` when the delay count expires.
- `ST_WINDOW` goes to `ST_DONE` when the window count expires.
- `ST_DONE` goes to `ST_IDLE` after one cycle.

Top module: `aow_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `meas_active` and `meas_done` are both 0.
- R2: The placement register resets to 1 (post-clamp) and the delay register resets to 1 (16 clocks). A cycle with `cfg_wr`=1 loads `cfg_after_clamp` and `cfg_long_delay` into them at that clock edge.
- R3: With placement 0 (in-clamp), `meas_active` is 1 in the cycle that follows the first clock edge at which `clamp` is sampled high. The delay register has no effect in this placement.
- R4: With placement 1 (post-clamp), `meas_active` rises N cycles after the first clock edge at which `clamp` is sampled low again. N is 10 when the delay register holds 0 and 16 when it holds 1.
- R5: Once opened and not restarted, `meas_active` stays high for exactly 6 consecutive cycles.
- R6: `meas_done` is high for exactly one cycle, the cycle right after the last `meas_active` cycle. It is never high together with `meas_active`.
- R7: A new clamp rising edge during a pending sequence (armed, delay or window) abandons that sequence and starts a new one from the rise.
- R8: The placement and delay settings are captured at the clamp rising edge. A register write made later in the same sequence does not alter that sequence's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clamp | input | 1 | Clamp pulse, synchronous to clk, active high |
| cfg_wr | input | 1 | Loads the two configuration bits |
| cfg_after_clamp | input | 1 | Placement: 0 in-clamp, 1 post-clamp |
| cfg_long_delay | input | 1 | Post-clamp delay: 0 gives 10 clocks, 1 gives 16 clocks |
| meas_active | output | 1 | Measurement window strobe |
| meas_done | output | 1 | One-cycle pulse after the window closes |

## Verification
Some properties are checked by assertions on every cycle:
- The completion pulse is single, follows an active cycle and never overlaps the strobe.
- No completion occurs before at least six consecutive active cycles.
- An in-clamp rise opens the strobe on the next cycle.

Other behaviour is shown only by the bench scenarios, which measure it at the ports:
- the exact post-clamp delay for each delay setting;
- the register reset defaults;
- the restart of a sequence by a new clamp edge;
- the immunity of a running sequence to mid-sequence register writes.

// File: rtl/aow_pkg.sv
package aow_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_DELAY  = 3'd2,
        ST_WINDOW = 3'd3,
        ST_DONE   = 3'd4
    } aow_state_e;

endpackage

// File: rtl/aow_cfg.sv
// Configuration holding register; both bits come out of reset at 1 (R2).
module aow_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic after_in,
    input  logic long_in,
    output logic after_q,
    output logic long_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            after_q <= 1'b1;
            long_q  <= 1'b1;
        end else if (wr) begin
            after_q <= after_in;
            long_q  <= long_in;
        end
    end
endmodule

// File: rtl/aow_edge.sv
// Clamp edge detector: one register of history.
module aow_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/aow_count.sv
// Shared down-counter for the delay and window phases.
module aow_count #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/aow_fsm.sv
module aow_fsm
    import aow_pkg::*;
#(
    parameter int WIN_LEN   = 6,
    parameter int DLY_SHORT = 10,
    parameter int DLY_LONG  = 16,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fall,
    input  logic             cfg_after,
    input  logic             cfg_long,
    input  logic             cnt_zero,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             dec,
    output logic             meas_active,
    output logic             meas_done
);
    localparam logic [CNT_W-1:0] WIN_LD   = CNT_W'(WIN_LEN - 1);
    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(DLY_SHORT - 1);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(DLY_LONG - 1);

    aow_state_e st, nxt;
    logic       run_long;

    // State register; delay choice captured at the clamp rise (R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            run_long <= 1'b1;
        end else begin
            st <= nxt;
            if (rise) run_long <= cfg_long;
        end
    end

    // Next state and counter control; a rise restarts from any state (R7).
    always_comb begin
        nxt      = st;
        load     = 1'b0;
        load_val = '0;
        dec      = 1'b0;
        if (rise) begin
            if (cfg_after) begin
                nxt = ST_ARMED;
            end else begin
                nxt      = ST_WINDOW;
                load     = 1'b1;
                load_val = WIN_LD;
            end
        end else begin
            unique case (st)
                ST_IDLE: nxt = ST_IDLE;
                ST_ARMED: begin
                    if (fall) begin
                        nxt      = ST_DELAY;
                        load     = 1'b1;
                        load_val = run_long ? LONG_LD : SHORT_LD;
                    end
                end
                ST_DELAY: begin
                    if (cnt_zero) begin
                        nxt      = ST_WINDOW;
                        load     = 1'b1;
                        load_val = WIN_LD;
                    end else begin
                        dec = 1'b1;
                    end
                end
                ST_WINDOW: begin
                    if (cnt_zero) nxt = ST_DONE;
                    else          dec = 1'b1;
                end
                ST_DONE: nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // Moore outputs.
    always_comb begin
        meas_active = (st == ST_WINDOW);
        meas_done   = (st == ST_DONE);
    end
endmodule

// File: rtl/aow_timer.sv
module aow_timer #(
    parameter int WIN_LEN   = 6,
    parameter int DLY_SHORT = 10,
    parameter int DLY_LONG  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clamp,
    input  logic cfg_wr,
    input  logic cfg_after_clamp,
    input  logic cfg_long_delay,
    output logic meas_active,
    output logic meas_done
);
    localparam int MAXV  = (DLY_LONG > WIN_LEN) ? DLY_LONG : WIN_LEN;
    localparam int CNT_W = $clog2(MAXV + 1);

    logic cfg_after_q, cfg_long_q;
    logic clamp_rise, clamp_fall;
    logic cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0] cnt_val;

    aow_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
        .after_in(cfg_after_clamp), .long_in(cfg_long_delay),
        .after_q(cfg_after_q), .long_q(cfg_long_q)
    );

    aow_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sig(clamp),
        .rise(clamp_rise), .fall(clamp_fall)
    );

    aow_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load),
        .load_val(cnt_val), .dec(cnt_dec), .zero(cnt_zero)
    );

    aow_fsm #(
        .WIN_LEN(WIN_LEN), .DLY_SHORT(DLY_SHORT),
        .DLY_LONG(DLY_LONG), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .rise(clamp_rise), .fall(clamp_fall),
        .cfg_after(cfg_after_q), .cfg_long(cfg_long_q), .cnt_zero(cnt_zero),
        .load(cnt_load), .load_val(cnt_val), .dec(cnt_dec),
        .meas_active(meas_active), .meas_done(meas_done)
    );
endmodule

// File: rtl/aow_timer_chk.sv
module aow_timer_chk #(
    parameter int WIN_LEN = 6
) (
    input logic clk,
    input logic rst_n,
    input logic clamp,
    input logic cfg_after_q,
    input logic meas_active,
    input logic meas_done
);
    logic [7:0] act_run;

    always_ff @(posedge clk) begin
        if (!rst_n)           act_run <= '0;
        else if (meas_active) act_run <= (act_run == 8'hFF) ? act_run : act_run + 1'b1;
        else                  act_run <= '0;
    end

    // R3: in-clamp rise opens the window on the next cycle
    a_r3_start_in_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp && !$past(clamp) && !cfg_after_q) |=> meas_active);

    // R6: completion is a single-cycle pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |=> !meas_done);

    // R6: completion follows an active cycle
    a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |-> $past(meas_active));

    // R6: strobe and completion never overlap
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(meas_active && meas_done));

    // R5: completion only after a full window
    a_r5_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |-> (act_run >= 8'(WIN_LEN)));
endmodule

bind aow_timer aow_timer_chk #(.WIN_LEN(WIN_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .clamp(clamp), .cfg_after_q(cfg_after_q),
    .meas_active(meas_active), .meas_done(meas_done)
);

// File: tb/aow_timer_test.sv
`timescale 1ns/1ps
module aow_timer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clamp = 1'b0;
    logic cfg_wr = 1'b0;
    logic cfg_after_clamp = 1'b0;
    logic cfg_long_delay = 1'b0;
    logic meas_active, meas_done;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    aow_timer uut (
        .clk(clk), .rst_n(rst_n), .clamp(clamp), .cfg_wr(cfg_wr),
        .cfg_after_clamp(cfg_after_clamp), .cfg_long_delay(cfg_long_delay),
        .meas_active(meas_active), .meas_done(meas_done)
    );

    // {after, long, clamp length[5:0]}
    localparam logic [7:0] VEC [6] = '{
        {1'b0, 1'b0, 6'd8}, {1'b0, 1'b1, 6'd3}, {1'b1, 1'b0, 6'd4},
        {1'b1, 1'b1, 6'd4}, {1'b1, 1'b0, 6'd1}, {1'b1, 1'b1, 6'd10}
    };

    task automatic check(input int act, input int exp, input string tag);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic a, input logic l);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_after_clamp = a; cfg_long_delay = l;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Drives clamp as pat[i] for edge e0+i; samples after each edge.
    task automatic run_seq(input logic [31:0] pat, input int wr_at,
                           input logic wa, input logic wl,
                           output int first_act, output int n_act,
                           output int first_done, output int n_done);
        first_act = -1; n_act = 0; first_done = -1; n_done = 0;
        @(negedge clk);
        clamp = pat[0];
        for (int i = 0; i < 64; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (meas_active) begin
                n_act++;
                if (first_act < 0) first_act = i;
            end
            if (meas_done) begin
                n_done++;
                if (first_done < 0) first_done = i;
            end
            clamp = (i + 1 < 32) ? pat[i+1] : 1'b0;
            cfg_wr = (i == wr_at);
            cfg_after_clamp = wa;
            cfg_long_delay = wl;
        end
        cfg_wr = 1'b0;
        clamp = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int fa, na, fd, nd, n, expst;
        logic a, l;
        logic [5:0] len;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(int'(meas_active), 0, "R1 active in reset");
        check(int'(meas_done), 0, "R1 done in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(meas_active), 0, "R1 active after reset");
        check(int'(meas_done), 0, "R1 done after reset");

        // R2: defaults post-clamp, 16 clocks, no write made
        run_seq(32'h3, -1, 1'b0, 1'b0, fa, na, fd, nd);
        check(fa, 2 + 16, "R2 default placement and delay start");
        check(na, 6, "R2 default window length R5");

        // Table of placements and delays (R3, R4, R5, R6)
        foreach (VEC[k]) begin
            a = VEC[k][7]; l = VEC[k][6]; len = VEC[k][5:0];
            write_cfg(a, l);
            n = l ? 16 : 10;
            expst = a ? int'(len) + n : 0;
            run_seq((32'h1 << len) - 1, -1, a, l, fa, na, fd, nd);
            check(fa, expst, a ? "R4 post-clamp start" : "R3 in-clamp start");
            check(na, 6, "R5 window length");
            check(fd, expst + 6, "R6 done position");
            check(nd, 1, "R6 done single");
        end

        // R7: in-clamp restart by a second rise during the window
        write_cfg(1'b0, 1'b0);
        run_seq(32'b1001, -1, 1'b0, 1'b0, fa, na, fd, nd);
        check(fa, 0, "R7 restart start");
        check(na, 9, "R7 restart extended window");
        check(fd, 9, "R7 restart done");

        // R7: post-clamp restart during the delay
        write_cfg(1'b1, 1'b0);
        run_seq(32'hC3, -1, 1'b0, 1'b0, fa, na, fd, nd);
        check(fa, 18, "R7 delay restart start");
        check(nd, 1, "R7 delay restart single done");

        // R8: mid-sequence write does not alter running sequence
        write_cfg(1'b1, 1'b1);
        run_seq(32'h3, 0, 1'b0, 1'b0, fa, na, fd, nd);
        check(fa, 2 + 16, "R8 capture at rise");
        check(na, 6, "R8 window length");
        // the write took effect for the next sequence (R3, R2)
        run_seq(32'h3, -1, 1'b0, 1'b0, fa, na, fd, nd);
        check(fa, 0, "R8 new setting on next rise");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule